// File: doc/BRIEF.md
# PTP frame timestamp snapshot unit

This unit latches the value of a free-running time counter on the cycle in which an Ethernet receive path flags a start-of-frame delimiter. The latched value waits in a pending register until an upstream parser reports the decoded PTP message type of that frame. Only then does the unit decide whether the frame is one that software asked for. A selected frame has its delimiter-time value written to the snapshot output. Any other frame has its pending value dropped.

Selection is programmed through a 32-bit control word. One bit chooses between PTP version 1 and version 2 message numbering. A 5-bit mode code chooses the message class. A lock bit turns on a freeze behaviour: the first selected capture is held against all later frames until software pulses a clear. A user mode compares the type against a programmable match value under a mask. In that mode the version bit has no effect.

Top module: `ptp_snap_unit`

## Requirements
- R1: After synchronous reset, `snap_valid_o` is 0, `snap_time_o` is 0 and the lock is released.
- R2: The time stored for a frame is the value of `tnow_i` in the cycle where `sfd_i` was 1, not the value present when the type is reported.
- R3: A selected frame reported with `cls_valid_i`=1 in cycle N shows its time on `snap_time_o`, with `snap_valid_o`=1, from cycle N+1.
- R4: With lock disabled (`ctrl_i[0]`=0), every selected frame overwrites the snapshot with its own delimiter time.
- R5: With lock enabled (`ctrl_i[0]`=1), the first selected frame after a clear sets the lock, and later selected frames leave `snap_time_o` unchanged until `sw_clear_i` is pulsed.
- R6: A `sw_clear_i` pulse drives `snap_valid_o` to 0 and releases the lock. If a selected frame is reported in the same cycle, the new frame is stored and `snap_valid_o` stays 1.
- R7: `ctrl_i[31]` selects the numbering. With 0 (version 1), valid types are 0..4 and the event types are 0 and 1. With 1 (version 2), valid types are 0..3 and 8..13, and the event types are 0..3. In both, type 0 is Sync and type 1 is Delay_Req. In version 2, types 2 and 3 are the peer delay request and response.
- R8: The mode code `ctrl_i[20:16]` selects the class: 0 Sync only, 1 Delay_Req only, 2 all event types, 3 all valid types.
- R9: Mode codes 4..7 and every code above 8 disable capture, so a reported frame changes neither `snap_time_o` nor `snap_valid_o`.
- R10: Mode code 8 selects a frame when `(type XOR ctrl_i[11:8]) AND ctrl_i[7:4]` is zero, whatever the value of `ctrl_i[31]`.
- R11: A frame that is not selected drops its pending time. A `cls_valid_i` with no pending time has no effect.
- R12: A second `sfd_i` before the type of the first frame is reported replaces the pending time with the newer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tnow_i | input | TW | Free-running time counter value |
| sfd_i | input | 1 | Start-of-frame delimiter strobe |
| cls_valid_i | input | 1 | Message type of the pending frame is valid |
| cls_type_i | input | TYW | Decoded PTP message type |
| ctrl_i | input | 32 | Control: [31] version, [20:16] mode, [11:8] user match, [7:4] user mask, [0] lock enable |
| sw_clear_i | input | 1 | Software clear pulse: drops valid, releases lock |
| snap_time_o | output | TW | Snapshot timestamp |
| snap_valid_o | output | 1 | Snapshot holds a captured frame |

## Verification
The pending register loads on the clock edge that closes the `sfd_i` cycle. The snapshot registers load on the edge that closes the `cls_valid_i` cycle, so a result is due one cycle after the type report. The bench drives inputs on falling edges and reads the outputs on the falling edge that follows the type-report cycle. One directed test also reads the outputs during the report cycle, to show that nothing changes early. After each delimiter the bench moves `tnow_i` to a different value. A wrong sampling point therefore shows up as a time mismatch, not as a timing difference.

// File: rtl/ptp_snap_pkg.sv
package ptp_snap_pkg;

  localparam int CTRL_W    = 32;
  localparam int VER_BIT   = 31;
  localparam int MODE_LO   = 16;
  localparam int MODE_W    = 5;
  localparam int UMATCH_LO = 8;
  localparam int UMASK_LO  = 4;
  localparam int LOCK_BIT  = 0;
  localparam int UFIELD_W  = 4;

  localparam logic [MODE_W-1:0] MODE_SYNC  = 5'd0;
  localparam logic [MODE_W-1:0] MODE_DREQ  = 5'd1;
  localparam logic [MODE_W-1:0] MODE_EVENT = 5'd2;
  localparam logic [MODE_W-1:0] MODE_ALL   = 5'd3;
  localparam logic [MODE_W-1:0] MODE_USER  = 5'd8;

  typedef struct packed {
    logic                ver2;
    logic [MODE_W-1:0]   mode;
    logic [UFIELD_W-1:0] umatch;
    logic [UFIELD_W-1:0] umask;
    logic                lock_en;
  } snap_ctrl_t;

  function automatic snap_ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] w);
    snap_ctrl_t c;
    c.ver2    = w[VER_BIT];
    c.mode    = w[MODE_LO +: MODE_W];
    c.umatch  = w[UMATCH_LO +: UFIELD_W];
    c.umask   = w[UMASK_LO +: UFIELD_W];
    c.lock_en = w[LOCK_BIT];
    return c;
  endfunction

  function automatic logic mode_reserved(input logic [MODE_W-1:0] m);
    return (m > MODE_ALL) && (m != MODE_USER);
  endfunction

endpackage

// File: rtl/ptp_msg_filter.sv
module ptp_msg_filter
  import ptp_snap_pkg::*;
#(
  parameter int TYW = 4
) (
  input  snap_ctrl_t     ctrl,
  input  logic [TYW-1:0] msg_type,
  output logic           qual
);
  localparam int NCODE = 1 << TYW;

  logic [NCODE-1:0] v1_evt, v1_all, v2_evt, v2_all;

  // Per-code class tables, built once per message code
  for (genvar c = 0; c < NCODE; c++) begin : g_cls
    assign v1_evt[c] = (c <= 1);
    assign v1_all[c] = (c <= 4);
    assign v2_evt[c] = (c <= 3);
    assign v2_all[c] = (c <= 3) || ((c >= 8) && (c <= 13));
  end

  logic [TYW-1:0] umatch_w, umask_w;
  assign umatch_w = TYW'(ctrl.umatch);
  assign umask_w  = TYW'(ctrl.umask);

  always_comb begin
    unique case (ctrl.mode)
      MODE_SYNC:  qual = (msg_type == TYW'(0));
      MODE_DREQ:  qual = (msg_type == TYW'(1));
      MODE_EVENT: qual = ctrl.ver2 ? v2_evt[msg_type] : v1_evt[msg_type];
      MODE_ALL:   qual = ctrl.ver2 ? v2_all[msg_type] : v1_all[msg_type];
      MODE_USER:  qual = ((msg_type ^ umatch_w) & umask_w) == '0;
      default:    qual = 1'b0;
    endcase
  end

endmodule

// File: rtl/ptp_stamp_pending.sv
module ptp_stamp_pending #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] tnow_i,
  input  logic          sfd_i,
  input  logic          consume_i,
  output logic [TW-1:0] pend_stamp_o,
  output logic          pend_vld_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_stamp_o <= '0;
      pend_vld_o   <= 1'b0;
    end else if (sfd_i) begin
      pend_stamp_o <= tnow_i;
      pend_vld_o   <= 1'b1;
    end else if (consume_i) begin
      pend_vld_o   <= 1'b0;
    end
  end

  p_sfd_sample_r2: assert property (@(posedge clk) disable iff (rst)
    sfd_i |=> pend_vld_o && (pend_stamp_o == $past(tnow_i)));

  p_consume_drops_r11: assert property (@(posedge clk) disable iff (rst)
    (consume_i && !sfd_i) |=> !pend_vld_o);

  p_hold_pending_r12: assert property (@(posedge clk) disable iff (rst)
    !sfd_i |=> $stable(pend_stamp_o));

endmodule

// File: rtl/ptp_snap_hold.sv
module ptp_snap_hold #(
  parameter int TW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit_i,
  input  logic [TW-1:0] commit_stamp_i,
  input  logic          lock_en_i,
  input  logic          sw_clear_i,
  output logic [TW-1:0] snap_time_o,
  output logic          snap_valid_o
);
  logic locked;
  logic accept;

  assign accept = commit_i && (!locked || sw_clear_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_time_o  <= '0;
      snap_valid_o <= 1'b0;
      locked       <= 1'b0;
    end else if (accept) begin
      snap_time_o  <= commit_stamp_i;
      snap_valid_o <= 1'b1;
      locked       <= lock_en_i;
    end else if (sw_clear_i) begin
      snap_valid_o <= 1'b0;
      locked       <= 1'b0;
    end
  end

  p_lock_freeze_r5: assert property (@(posedge clk) disable iff (rst)
    (locked && !sw_clear_i) |=> $stable(snap_time_o) && snap_valid_o);

  p_clear_release_r6: assert property (@(posedge clk) disable iff (rst)
    (sw_clear_i && !commit_i) |=> !snap_valid_o && !locked);

  p_commit_shows_r3: assert property (@(posedge clk) disable iff (rst)
    (commit_i && !locked) |=> snap_valid_o && (snap_time_o == $past(commit_stamp_i)));

  p_clear_commit_r6: assert property (@(posedge clk) disable iff (rst)
    (commit_i && sw_clear_i) |=> snap_valid_o);

endmodule

// File: rtl/ptp_snap_unit.sv
module ptp_snap_unit
  import ptp_snap_pkg::*;
#(
  parameter int TW  = 64,
  parameter int TYW = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     tnow_i,
  input  logic              sfd_i,
  input  logic              cls_valid_i,
  input  logic [TYW-1:0]    cls_type_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              sw_clear_i,
  output logic [TW-1:0]     snap_time_o,
  output logic              snap_valid_o
);
  snap_ctrl_t    ctrl;
  logic [TW-1:0] pend_stamp;
  logic          pend_vld;
  logic          qual;
  logic          commit;
  logic          unused_ctrl_bits;

  assign ctrl             = unpack_ctrl(ctrl_i);
  assign unused_ctrl_bits = ^{ctrl_i[30:21], ctrl_i[15:12], ctrl_i[3:1]};

  ptp_stamp_pending #(.TW(TW)) u_pend (
    .clk          (clk),
    .rst          (rst),
    .tnow_i       (tnow_i),
    .sfd_i        (sfd_i),
    .consume_i    (cls_valid_i),
    .pend_stamp_o (pend_stamp),
    .pend_vld_o   (pend_vld)
  );

  ptp_msg_filter #(.TYW(TYW)) u_filt (
    .ctrl     (ctrl),
    .msg_type (cls_type_i),
    .qual     (qual)
  );

  assign commit = cls_valid_i && pend_vld && qual;

  ptp_snap_hold #(.TW(TW)) u_hold (
    .clk            (clk),
    .rst            (rst),
    .commit_i       (commit),
    .commit_stamp_i (pend_stamp),
    .lock_en_i      (ctrl.lock_en),
    .sw_clear_i     (sw_clear_i),
    .snap_time_o    (snap_time_o),
    .snap_valid_o   (snap_valid_o)
  );

  p_reserved_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (cls_valid_i && !sw_clear_i && mode_reserved(ctrl.mode))
      |=> $stable(snap_time_o) && $stable(snap_valid_o));

  p_no_pending_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (cls_valid_i && !pend_vld && !sw_clear_i)
      |=> $stable(snap_time_o) && $stable(snap_valid_o));

endmodule

// File: tb/tb_ptp_snap_unit.sv
module tb_ptp_snap_unit;
  localparam int TW  = 64;
  localparam int TYW = 4;
  localparam int NV  = 26;

  logic          clk = 1'b0;
  logic          rst;
  logic [TW-1:0] tnow_i;
  logic          sfd_i, cls_valid_i, sw_clear_i;
  logic [TYW-1:0] cls_type_i;
  logic [31:0]   ctrl_i;
  logic [TW-1:0] snap_time_o;
  logic          snap_valid_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  ptp_snap_unit #(.TW(TW), .TYW(TYW)) dut (
    .clk(clk), .rst(rst), .tnow_i(tnow_i), .sfd_i(sfd_i),
    .cls_valid_i(cls_valid_i), .cls_type_i(cls_type_i), .ctrl_i(ctrl_i),
    .sw_clear_i(sw_clear_i), .snap_time_o(snap_time_o), .snap_valid_o(snap_valid_o)
  );

  // {version, mode, type, expected-select}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {1'b0, 5'd0, 4'd0,  1'b1}, {1'b0, 5'd0, 4'd1,  1'b0},
    {1'b0, 5'd1, 4'd1,  1'b1}, {1'b0, 5'd1, 4'd0,  1'b0},
    {1'b0, 5'd2, 4'd0,  1'b1}, {1'b0, 5'd2, 4'd1,  1'b1},
    {1'b0, 5'd2, 4'd2,  1'b0}, {1'b0, 5'd2, 4'd3,  1'b0},
    {1'b0, 5'd3, 4'd4,  1'b1}, {1'b0, 5'd3, 4'd5,  1'b0},
    {1'b0, 5'd3, 4'd2,  1'b1}, {1'b1, 5'd0, 4'd0,  1'b1},
    {1'b1, 5'd0, 4'd8,  1'b0}, {1'b1, 5'd1, 4'd1,  1'b1},
    {1'b1, 5'd2, 4'd2,  1'b1}, {1'b1, 5'd2, 4'd3,  1'b1},
    {1'b1, 5'd2, 4'd8,  1'b0}, {1'b1, 5'd3, 4'd8,  1'b1},
    {1'b1, 5'd3, 4'd13, 1'b1}, {1'b1, 5'd3, 4'd14, 1'b0},
    {1'b1, 5'd3, 4'd4,  1'b0}, {1'b1, 5'd4, 4'd0,  1'b0},
    {1'b1, 5'd7, 4'd0,  1'b0}, {1'b0, 5'd9, 4'd0,  1'b0},
    {1'b1, 5'd31, 4'd0, 1'b0}, {1'b0, 5'd5, 4'd1,  1'b0}
  };

  function automatic logic [31:0] mk_ctrl(input logic ver, input logic [4:0] mode,
                                          input logic lock, input logic [3:0] um,
                                          input logic [3:0] uk);
    return {ver, 10'b0, mode, 4'b0, um, uk, 3'b0, lock};
  endfunction

  task automatic chk(input string req, input logic [TW-1:0] got, input logic [TW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic frame(input logic [TW-1:0] t, input logic [TYW-1:0] ty);
    @(negedge clk); tnow_i = t; sfd_i = 1'b1;
    @(negedge clk); sfd_i = 1'b0; tnow_i = t + 64'd999;
    @(negedge clk); cls_valid_i = 1'b1; cls_type_i = ty;
    @(negedge clk); cls_valid_i = 1'b0;
  endtask

  task automatic swclr();
    @(negedge clk); sw_clear_i = 1'b1;
    @(negedge clk); sw_clear_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; tnow_i = '0; sfd_i = 0; cls_valid_i = 0; cls_type_i = '0;
    sw_clear_i = 0; ctrl_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid", TW'(snap_valid_o), 0);
    chk("R1 time",  snap_time_o, 0);

    // Table walk: R2, R7, R8, R9
    for (int i = 0; i < NV; i++) begin
      logic [TW-1:0] t;
      t = 64'h1_0000 + 64'(i) * 64'h101;
      ctrl_i = mk_ctrl(VEC[i][10], VEC[i][9:5], 1'b0, 4'd0, 4'd0);
      swclr();
      frame(t, VEC[i][4:1]);
      chk($sformatf("R7/R8/R9 vec %0d valid", i), TW'(snap_valid_o), TW'(VEC[i][0]));
      if (VEC[i][0]) chk($sformatf("R2 vec %0d time", i), snap_time_o, t);
    end

    // R3: nothing before the edge closing the report cycle, result right after
    ctrl_i = mk_ctrl(1'b1, 5'd3, 1'b0, 4'd0, 4'd0);
    swclr();
    @(negedge clk); tnow_i = 64'hAA; sfd_i = 1;
    @(negedge clk); sfd_i = 0; tnow_i = 64'hBB;
    @(negedge clk); cls_valid_i = 1; cls_type_i = 4'd0;
    #1 chk("R3 not early", TW'(snap_valid_o), 0);
    @(negedge clk); cls_valid_i = 0;
    chk("R3 valid due", TW'(snap_valid_o), 1);
    chk("R3 time due", snap_time_o, 64'hAA);

    // R4: overwrite when unlocked
    frame(64'h200, 4'd8);
    chk("R4 overwrite", snap_time_o, 64'h200);
    frame(64'h300, 4'd1);
    chk("R4 overwrite again", snap_time_o, 64'h300);

    // R9: reserved mode leaves an existing snapshot alone
    ctrl_i = mk_ctrl(1'b1, 5'd6, 1'b0, 4'd0, 4'd0);
    frame(64'h350, 4'd0);
    chk("R9 time kept", snap_time_o, 64'h300);
    chk("R9 valid kept", TW'(snap_valid_o), 1);

    // R5: lock
    ctrl_i = mk_ctrl(1'b1, 5'd3, 1'b1, 4'd0, 4'd0);
    swclr();
    frame(64'h400, 4'd0);
    chk("R5 first capture", snap_time_o, 64'h400);
    frame(64'h500, 4'd1);
    chk("R5 frozen", snap_time_o, 64'h400);
    chk("R5 still valid", TW'(snap_valid_o), 1);

    // R6: clear together with a selected report stores the new frame
    @(negedge clk); tnow_i = 64'h600; sfd_i = 1;
    @(negedge clk); sfd_i = 0; tnow_i = 64'h6FF;
    @(negedge clk); cls_valid_i = 1; cls_type_i = 4'd0; sw_clear_i = 1;
    @(negedge clk); cls_valid_i = 0; sw_clear_i = 0;
    chk("R6 clear+commit time", snap_time_o, 64'h600);
    chk("R6 clear+commit valid", TW'(snap_valid_o), 1);
    swclr();
    chk("R6 clear drops valid", TW'(snap_valid_o), 0);
    frame(64'h700, 4'd2);
    chk("R6 lock released", snap_time_o, 64'h700);

    // R12: newer delimiter replaces pending time
    ctrl_i = mk_ctrl(1'b1, 5'd3, 1'b0, 4'd0, 4'd0);
    swclr();
    @(negedge clk); tnow_i = 64'h800; sfd_i = 1;
    @(negedge clk); sfd_i = 0;
    @(negedge clk); tnow_i = 64'h900; sfd_i = 1;
    @(negedge clk); sfd_i = 0; tnow_i = 64'h999;
    @(negedge clk); cls_valid_i = 1; cls_type_i = 4'd0;
    @(negedge clk); cls_valid_i = 0;
    chk("R12 newer stamp", snap_time_o, 64'h900);

    // R11: unselected frame drops pending; report with nothing pending ignored
    swclr();
    frame(64'hA00, 4'd14);
    chk("R11 unselected", TW'(snap_valid_o), 0);
    @(negedge clk); cls_valid_i = 1; cls_type_i = 4'd0;
    @(negedge clk); cls_valid_i = 0;
    chk("R11 no pending", TW'(snap_valid_o), 0);

    // R10: user match under mask, version ignored
    ctrl_i = mk_ctrl(1'b0, 5'd8, 1'b0, 4'd5, 4'hF);
    swclr();
    frame(64'hB00, 4'd5);
    chk("R10 exact v1", snap_time_o, 64'hB00);
    ctrl_i = mk_ctrl(1'b1, 5'd8, 1'b0, 4'd5, 4'hF);
    frame(64'hB10, 4'd5);
    chk("R10 exact v2", snap_time_o, 64'hB10);
    ctrl_i = mk_ctrl(1'b1, 5'd8, 1'b0, 4'd8, 4'hC);
    frame(64'hB20, 4'hB);
    chk("R10 masked hit", snap_time_o, 64'hB20);
    frame(64'hB30, 4'h4);
    chk("R10 masked miss", snap_time_o, 64'hB20);

    // R1: reset in mid-operation
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset valid", TW'(snap_valid_o), 0);
    chk("R1 reset time", snap_time_o, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule